// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits in front of a small word memory that several bus masters share. It supports load-linked / store-conditional pairs. When a master issues an exclusive read, the monitor remembers that this master holds a reservation on the 32-bit word it read. When the same master later issues an exclusive write, the write reaches memory only if that reservation is still intact. Otherwise the write is dropped and the master is told that the store failed.

Three kinds of event break a reservation: the master's core entering an exception, an explicit clear from that master, and a memory write by any other master to the reserved word. Each exclusive access is answered with an exclusive-okay or a plain-okay code. The block also returns a status bit meant for a core register: 0 means the store succeeded and 1 means it failed. It does not produce a condition flag.

Responses, status and read data appear one clock cycle after the request. Memory writes take effect at the same clock edge that registers the response.

Top module: `xmon_top`

## Requirements
- R1: An exclusive read (valid=1, write=0, excl=1) records a reservation for that master on the granule of its address (address bits [ADDR_W-1:2]). Its response has exok=1, fail=0 and carries the word that memory held before that cycle's writes.
- R2: An exclusive write whose granule equals the master's valid reservation writes memory and responds exok=1, fail=0 (status 0 means success).
- R3: A failed exclusive write leaves memory unchanged and responds exok=0 (plain okay), fail=1 (status 1 means failure).
- R4: Asserting exc_entry for a master cancels that master's reservation, so its next exclusive write fails.
- R5: Asserting clr_resv for a master cancels that master's reservation, so its next exclusive write fails.
- R6: A memory write by a different master to any byte of the reserved granule cancels the reservation. A plain write by the holder itself does not cancel it.
- R7: A master holds at most one reservation. A new exclusive read replaces the earlier one.
- R8: An exclusive write to a granule other than the reserved one fails and leaves memory unchanged.
- R9: Every exclusive write clears the issuing master's reservation, whatever its outcome. A second exclusive write with no new exclusive read therefore fails.
- R10: When several masters issue eligible exclusive writes to the same granule in the same cycle, only the lowest-numbered master succeeds. The others fail.
- R11: A plain access always completes: a plain write updates memory and a plain read returns data. Its response is exok=0, fail=0, and rsp_valid follows req_valid one cycle later.
- R12: After synchronous reset, no reservation is held, all response outputs are 0 and memory reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_M | Request present, one bit per master |
| req_addr | input | NUM_M*ADDR_W | Byte address per master |
| req_write | input | NUM_M | 1 = write, 0 = read |
| req_excl | input | NUM_M | Exclusive access flag |
| req_wdata | input | NUM_M*DATA_W | Write data per master |
| clr_resv | input | NUM_M | Drop that master's reservation |
| exc_entry | input | NUM_M | That master's core is entering an exception |
| mem_we | output | NUM_M | Write from that master is committed this cycle |
| rsp_valid | output | NUM_M | Response present |
| rsp_exok | output | NUM_M | 1 = exclusive-okay, 0 = plain okay |
| rsp_fail | output | NUM_M | Exclusive write status: 1 = failed |
| rsp_rdata | output | NUM_M*DATA_W | Read data |

## Verification
The assertions assume that every control input is a clean 0 or 1 on each rising edge. They also assume that request fields matter only while req_valid is high, since the design masks them otherwise. The stimulus changes inputs only on the falling edge and returns every unused field to zero after each operation. Same-cycle contention is created on purpose, and only in the arbitration scenario, where two exclusive writes target one granule.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

    // Exclusive monitoring works on aligned 32-bit words.
    localparam int GRAN_LSB = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_LDX,
        ACC_STX
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic vld, input logic wr, input logic ex);
        if (!vld)
            return ACC_NONE;
        else if (ex)
            return wr ? ACC_STX : ACC_LDX;
        else
            return wr ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/xmon_resv_slot.sv
module xmon_resv_slot #(
    parameter int GW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [GW-1:0] set_gran,
    input  logic          kill,
    output logic          held,
    output logic [GW-1:0] held_gran
);
    // A kill in the same cycle wins over a new exclusive read.
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_gran <= '0;
        end else if (kill) begin
            held      <= 1'b0;
        end else if (set_en) begin
            held      <= 1'b1;
            held_gran <= set_gran;
        end
    end
endmodule

// File: rtl/xmon_store_arb.sv
module xmon_store_arb #(
    parameter int NUM_M = 3,
    parameter int GW    = 6
) (
    input  logic [NUM_M-1:0]    is_stx,
    input  logic [NUM_M-1:0]    is_pwr,
    input  logic [NUM_M*GW-1:0] gran,
    input  logic [NUM_M-1:0]    resv_held,
    input  logic [NUM_M*GW-1:0] resv_gran,
    input  logic [NUM_M-1:0]    cancel_now,
    output logic [NUM_M-1:0]    stx_ok
);
    always_comb begin
        logic [NUM_M-1:0] won;
        won = '0;
        for (int i = 0; i < NUM_M; i++) begin
            won[i] = is_stx[i] && resv_held[i] && !cancel_now[i]
                     && (resv_gran[i*GW +: GW] == gran[i*GW +: GW]);
            for (int j = 0; j < NUM_M; j++) begin
                if (j != i && is_pwr[j] && gran[j*GW +: GW] == gran[i*GW +: GW])
                    won[i] = 1'b0;
                if (j < i && won[j] && gran[j*GW +: GW] == gran[i*GW +: GW])
                    won[i] = 1'b0;
            end
        end
        stx_ok = won;
    end
endmodule

// File: rtl/xmon_mem.sv
module xmon_mem #(
    parameter int NUM_M = 3,
    parameter int IW    = 6,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_M-1:0]    we,
    input  logic [NUM_M*IW-1:0] idx,
    input  logic [NUM_M*DW-1:0] wdata,
    output logic [NUM_M*DW-1:0] rdata
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] store [DEPTH];

    // Writes commit in ascending master order.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                store[k] <= '0;
        end else begin
            for (int m = 0; m < NUM_M; m++)
                if (we[m])
                    store[idx[m*IW +: IW]] <= wdata[m*DW +: DW];
        end
    end

    for (genvar g = 0; g < NUM_M; g++) begin : g_rd
        assign rdata[g*DW +: DW] = store[idx[g*IW +: IW]];
    end
endmodule

// File: rtl/xmon_top.sv
module xmon_top
    import xmon_pkg::*;
#(
    parameter int NUM_M  = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_M-1:0]        req_valid,
    input  logic [NUM_M*ADDR_W-1:0] req_addr,
    input  logic [NUM_M-1:0]        req_write,
    input  logic [NUM_M-1:0]        req_excl,
    input  logic [NUM_M*DATA_W-1:0] req_wdata,
    input  logic [NUM_M-1:0]        clr_resv,
    input  logic [NUM_M-1:0]        exc_entry,
    output logic [NUM_M-1:0]        mem_we,
    output logic [NUM_M-1:0]        rsp_valid,
    output logic [NUM_M-1:0]        rsp_exok,
    output logic [NUM_M-1:0]        rsp_fail,
    output logic [NUM_M*DATA_W-1:0] rsp_rdata
);
    localparam int GW = ADDR_W - GRAN_LSB;

    acc_kind_e            kind [NUM_M];
    logic [NUM_M*GW-1:0]  gran_flat;
    logic [NUM_M-1:0]     is_ldx, is_stx, is_pwr, is_rd;
    logic [NUM_M-1:0]     resv_v;
    logic [NUM_M*GW-1:0]  resv_g;
    logic [NUM_M-1:0]     stx_ok;
    logic [NUM_M-1:0]     other_hit;
    logic [NUM_M*DATA_W-1:0] mem_rd;

    for (genvar g = 0; g < NUM_M; g++) begin : g_dec
        assign kind[g] = classify(req_valid[g], req_write[g], req_excl[g]);
        assign gran_flat[g*GW +: GW] = req_addr[g*ADDR_W + GRAN_LSB +: GW];
        assign is_ldx[g] = (kind[g] == ACC_LDX);
        assign is_stx[g] = (kind[g] == ACC_STX);
        assign is_pwr[g] = (kind[g] == ACC_WRITE);
        assign is_rd[g]  = (kind[g] == ACC_READ) || (kind[g] == ACC_LDX);
    end

    xmon_store_arb #(.NUM_M(NUM_M), .GW(GW)) u_arb (
        .is_stx     (is_stx),
        .is_pwr     (is_pwr),
        .gran       (gran_flat),
        .resv_held  (resv_v),
        .resv_gran  (resv_g),
        .cancel_now (exc_entry | clr_resv),
        .stx_ok     (stx_ok)
    );

    assign mem_we = is_pwr | stx_ok;

    // A committed write from any other master to a held granule snoops it away.
    always_comb begin
        other_hit = '0;
        for (int i = 0; i < NUM_M; i++)
            for (int j = 0; j < NUM_M; j++)
                if (j != i && mem_we[j] && gran_flat[j*GW +: GW] == resv_g[i*GW +: GW])
                    other_hit[i] = 1'b1;
    end

    for (genvar g = 0; g < NUM_M; g++) begin : g_slot
        xmon_resv_slot #(.GW(GW)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .set_en    (is_ldx[g]),
            .set_gran  (gran_flat[g*GW +: GW]),
            .kill      (exc_entry[g] | clr_resv[g] | is_stx[g] | other_hit[g]),
            .held      (resv_v[g]),
            .held_gran (resv_g[g*GW +: GW])
        );
    end

    xmon_mem #(.NUM_M(NUM_M), .IW(GW), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .idx   (gran_flat),
        .wdata (req_wdata),
        .rdata (mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_exok  <= '0;
            rsp_fail  <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_exok  <= is_ldx | stx_ok;
            rsp_fail  <= is_stx & ~stx_ok;
            for (int m = 0; m < NUM_M; m++)
                rsp_rdata[m*DATA_W +: DATA_W] <= is_rd[m] ? mem_rd[m*DATA_W +: DATA_W] : '0;
        end
    end
endmodule

// File: rtl/xmon_chk.sv
module xmon_chk #(
    parameter int NUM_M  = 3,
    parameter int ADDR_W = 8,
    parameter int GW     = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_M-1:0]        req_valid,
    input logic [NUM_M*ADDR_W-1:0] req_addr,
    input logic [NUM_M-1:0]        req_write,
    input logic [NUM_M-1:0]        req_excl,
    input logic [NUM_M-1:0]        clr_resv,
    input logic [NUM_M-1:0]        exc_entry,
    input logic [NUM_M-1:0]        mem_we,
    input logic [NUM_M-1:0]        rsp_valid,
    input logic [NUM_M-1:0]        rsp_exok,
    input logic [NUM_M-1:0]        rsp_fail,
    input logic [NUM_M-1:0]        resv_v,
    input logic [NUM_M*GW-1:0]     resv_g
);
    localparam int LSB = ADDR_W - GW;

    for (genvar i = 0; i < NUM_M; i++) begin : g_m
        logic stx_i, ldx_i;
        assign stx_i = req_valid[i] && req_write[i] && req_excl[i];
        assign ldx_i = req_valid[i] && !req_write[i] && req_excl[i];

        // R1
        ldx_sets_resv_chk: assert property (@(posedge clk) disable iff (rst)
            (ldx_i && !exc_entry[i] && !clr_resv[i] && mem_we == '0)
            |=> (resv_v[i] && resv_g[i*GW +: GW] == $past(req_addr[i*ADDR_W + LSB +: GW])));

        // R2
        no_resv_no_write_chk: assert property (@(posedge clk) disable iff (rst)
            (stx_i && !resv_v[i]) |-> !mem_we[i]);

        // R3
        fail_is_plain_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_fail[i] |-> !rsp_exok[i]);

        // R4
        exc_cancels_chk: assert property (@(posedge clk) disable iff (rst)
            exc_entry[i] |=> !resv_v[i]);

        // R5
        clr_cancels_chk: assert property (@(posedge clk) disable iff (rst)
            clr_resv[i] |=> !resv_v[i]);

        // R9
        stx_clears_chk: assert property (@(posedge clk) disable iff (rst)
            stx_i |=> !resv_v[i]);

        // R11
        rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
            req_valid[i] |=> rsp_valid[i]);

        // R11
        no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
            !req_valid[i] |=> !rsp_valid[i]);

        for (genvar j = 0; j < i; j++) begin : g_pair
            // R10
            single_winner_chk: assert property (@(posedge clk) disable iff (rst)
                !(mem_we[i] && mem_we[j] && req_excl[i] && req_excl[j]
                  && req_addr[i*ADDR_W + LSB +: GW] == req_addr[j*ADDR_W + LSB +: GW]));
        end
    end
endmodule

bind xmon_top xmon_chk #(
    .NUM_M  (NUM_M),
    .ADDR_W (ADDR_W),
    .GW     (ADDR_W - xmon_pkg::GRAN_LSB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_excl  (req_excl),
    .clr_resv  (clr_resv),
    .exc_entry (exc_entry),
    .mem_we    (mem_we),
    .rsp_valid (rsp_valid),
    .rsp_exok  (rsp_exok),
    .rsp_fail  (rsp_fail),
    .resv_v    (resv_v),
    .resv_g    (resv_g)
);

// File: tb/xmon_top_tb.sv
`timescale 1ns/1ps
module xmon_top_tb;
    localparam int N  = 3;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0]    v, w, x, clr, exc;
    logic [N*AW-1:0] a;
    logic [N*DW-1:0] d;
    logic [N-1:0]    mem_we, rsp_valid, rsp_exok, rsp_fail;
    logic [N*DW-1:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xmon_top #(.NUM_M(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(v), .req_addr(a), .req_write(w), .req_excl(x), .req_wdata(d),
        .clr_resv(clr), .exc_entry(exc),
        .mem_we(mem_we), .rsp_valid(rsp_valid), .rsp_exok(rsp_exok),
        .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        v = '0; w = '0; x = '0; clr = '0; exc = '0; a = '0; d = '0;
    endtask

    // One operation on one master; called at a falling edge, returns at the next one.
    task automatic op(input int m, input logic [7:0] ad, input bit wr, input bit ex,
                      input logic [31:0] dat, output bit ok, output bit fl,
                      output logic [31:0] rd);
        v[m] = 1'b1; w[m] = wr; x[m] = ex;
        a[m*AW +: AW] = ad; d[m*DW +: DW] = dat;
        @(posedge clk); @(negedge clk);
        ok = rsp_exok[m]; fl = rsp_fail[m]; rd = rsp_rdata[m*DW +: DW];
        idle();
    endtask

    task automatic rd_word(input int m, input logic [7:0] ad, output logic [31:0] rd);
        bit ok, fl;
        op(m, ad, 1'b0, 1'b0, '0, ok, fl, rd);
    endtask

    task automatic pulse(input int m, input bit is_exc);
        if (is_exc) exc[m] = 1'b1; else clr[m] = 1'b1;
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R12 rsp_valid", {29'd0, rsp_valid}, 32'd0);
        chk("R12 rsp_fail", {29'd0, rsp_fail}, 32'd0);
        rd_word(1, 8'h10, r);
        chk("R12 mem zero", r, 32'd0);
    endtask

    task automatic t_basic();
        bit ok, fl; logic [31:0] r;
        op(0, 8'h10, 1, 0, 32'hAAAA_0001, ok, fl, r);
        chk("R11 plain write exok", {31'd0, ok}, 32'd0);
        chk("R11 plain write fail", {31'd0, fl}, 32'd0);
        op(0, 8'h10, 0, 1, 0, ok, fl, r);
        chk("R1 ldx exok", {31'd0, ok}, 32'd1);
        chk("R1 ldx data", r, 32'hAAAA_0001);
        op(0, 8'h12, 1, 1, 32'h1234_5678, ok, fl, r);
        chk("R2 stx exok", {31'd0, ok}, 32'd1);
        chk("R2 stx status", {31'd0, fl}, 32'd0);
        rd_word(1, 8'h10, r);
        chk("R2 mem updated", r, 32'h1234_5678);
        op(0, 8'h10, 1, 1, 32'hDEAD_0000, ok, fl, r);
        chk("R9 second stx status", {31'd0, fl}, 32'd1);
        chk("R3 failed stx exok", {31'd0, ok}, 32'd0);
        rd_word(2, 8'h10, r);
        chk("R3 mem unchanged", r, 32'h1234_5678);
    endtask

    task automatic t_cancel(input bit is_exc);
        bit ok, fl; logic [31:0] r;
        op(1, 8'h20, 0, 1, 0, ok, fl, r);
        pulse(1, is_exc);
        op(1, 8'h20, 1, 1, 32'h0000_0BAD, ok, fl, r);
        chk(is_exc ? "R4 exc stx status" : "R5 clr stx status", {31'd0, fl}, 32'd1);
        rd_word(0, 8'h20, r);
        chk(is_exc ? "R4 mem unchanged" : "R5 mem unchanged", r, 32'd0);
    endtask

    task automatic t_snoop();
        bit ok, fl; logic [31:0] r;
        op(0, 8'h30, 0, 1, 0, ok, fl, r);
        op(1, 8'h33, 1, 0, 32'h5, ok, fl, r);
        op(0, 8'h30, 1, 1, 32'h9, ok, fl, r);
        chk("R6 other write cancels", {31'd0, fl}, 32'd1);
        rd_word(0, 8'h30, r);
        chk("R6 other data kept", r, 32'h5);
        op(2, 8'h40, 0, 1, 0, ok, fl, r);
        op(2, 8'h40, 1, 0, 32'h7, ok, fl, r);
        op(2, 8'h40, 1, 1, 32'h8, ok, fl, r);
        chk("R6 own write keeps resv", {31'd0, fl}, 32'd0);
        rd_word(0, 8'h40, r);
        chk("R6 own stx data", r, 32'h8);
    endtask

    task automatic t_replace();
        bit ok, fl; logic [31:0] r;
        op(0, 8'h50, 0, 1, 0, ok, fl, r);
        op(0, 8'h54, 0, 1, 0, ok, fl, r);
        op(0, 8'h54, 1, 1, 32'h54, ok, fl, r);
        chk("R7 newest resv wins", {31'd0, fl}, 32'd0);
        op(0, 8'h50, 0, 1, 0, ok, fl, r);
        op(0, 8'h54, 0, 1, 0, ok, fl, r);
        op(0, 8'h50, 1, 1, 32'h50, ok, fl, r);
        chk("R8 wrong granule fails", {31'd0, fl}, 32'd1);
        rd_word(1, 8'h50, r);
        chk("R8 mem unchanged", r, 32'd0);
        op(0, 8'h54, 1, 1, 32'h99, ok, fl, r);
        chk("R8 resv cleared", {31'd0, fl}, 32'd1);
        rd_word(1, 8'h54, r);
        chk("R9 mem kept", r, 32'h54);
    endtask

    task automatic t_race(input int lo, input int hi, input logic [7:0] ad);
        bit ok, fl; logic [31:0] r;
        op(lo, ad, 0, 1, 0, ok, fl, r);
        op(hi, ad, 0, 1, 0, ok, fl, r);
        v[lo] = 1; w[lo] = 1; x[lo] = 1; a[lo*AW +: AW] = ad; d[lo*DW +: DW] = 32'h11;
        v[hi] = 1; w[hi] = 1; x[hi] = 1; a[hi*AW +: AW] = ad; d[hi*DW +: DW] = 32'h22;
        @(posedge clk); @(negedge clk);
        chk("R10 low master wins", {31'd0, rsp_fail[lo]}, 32'd0);
        chk("R10 high master fails", {31'd0, rsp_fail[hi]}, 32'd1);
        idle();
        rd_word(0, ad, r);
        chk("R10 mem holds winner", r, 32'h11);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_cancel(1'b1);
        t_cancel(1'b0);
        t_snoop();
        t_replace();
        t_race(0, 2, 8'h60);
        t_race(1, 2, 8'h64);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule